// File: doc/BRIEF.md
# Iterative Shift-Add Vector Rotator

This block rotates a two-dimensional fixed-point vector through an angle, or turns a vector onto the positive x axis while it measures the angle it turned through. One shift-add stage is reused for a fixed number of clock cycles. On each cycle the vector is nudged by a pseudorotation through plus or minus atan(2^-i), and a third register keeps the running angle. A host raises `start` for one cycle with the operands and the mode. A single-cycle `done` pulse follows a fixed number of cycles later, and the three result words then stay valid until the next operation ends.

In rotation mode the direction of each step follows the sign of the remaining angle, so the angle register is driven toward zero. Loading x with the inverse of the total stage gain (about 0.607253) and y with zero returns the cosine and sine of the input angle directly. In vectoring mode the direction follows the sign of y, so y is driven toward zero. The angle register then gathers the arctangent of y/x, added to its start value, and x ends as the gained vector length.

Top module: `cordic_rotator`

## Requirements
- R1: Synchronous active-high `rst` clears `done`, `x_out`, `y_out` and `z_out` to zero.
- R2: With `mode` = 0 (rotation), each step uses d = +1 when the remaining angle is zero or positive and d = -1 otherwise. The result is x_out ≈ G·(x·cos z − y·sin z) and y_out ≈ G·(y·cos z + x·sin z) with z_out ≈ 0, where G ≈ 1.646760. All words are two's-complement with 15 fraction bits, and angles are in radians.
- R3: With `mode` = 1 (vectoring) and x_in > 0, each step uses d = −1 when y is zero or positive and d = +1 otherwise. The result is y_out ≈ 0, x_out ≈ G·sqrt(x² + y²) and z_out ≈ z_in + atan(y/x).
- R4: Rotation angles up to about ±1.74 rad (±99.7°) converge, including angles beyond ±90° where the cosine is negative.
- R5: `done` rises on the ITER-th rising clock edge after the edge that accepts `start` (16 with default parameters).
- R6: `done` is high for exactly one clock cycle per accepted operation.
- R7: A `start` raised while an operation is in progress is ignored. It neither alters the result nor causes an extra `done`.
- R8: `x_out`, `y_out` and `z_out` change only on the edge that raises `done`. Between operations they hold, whatever the inputs do.
- R9: Loading x_in ≈ 0.607253 and y_in = 0 in rotation mode yields cos z and sin z without scaling, within about 0.003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 1 | 0 rotation, 1 vectoring |
| x_in | input | DATA_W | Initial x, signed, FRAC_W fraction bits |
| y_in | input | DATA_W | Initial y, signed, FRAC_W fraction bits |
| z_in | input | DATA_W | Initial angle in radians, signed, FRAC_W fraction bits |
| done | output | 1 | One-cycle result-valid pulse |
| x_out | output | DATA_W | Final x |
| y_out | output | DATA_W | Final y |
| z_out | output | DATA_W | Final residual or accumulated angle |

## Verification
Rotation is run from the gain-compensated unit vector at positive, negative, zero and beyond-right-angle targets. These runs separate a wrong direction rule, a wrong table entry and a missing sign extension on the shifts, because each one pushes cosine or sine out of tolerance in a different quadrant. A rotation of a general vector that starts off the x axis exposes exchanged or mis-signed cross terms. Vectoring is run with positive and negative y and with a nonzero start angle, which separates the sign choice of the y rule from the accumulation into z. Latency, a second start while busy, and holding after completion are checked at the cycle level.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_VECTOR = 1'b1
  } cordic_mode_e;

  // atan(2^-i) scaled by 2^32, rounded
  function automatic longint atan_q32(input int i);
    case (i)
      0:  return 64'd3373259426;
      1:  return 64'd1991351318;
      2:  return 64'd1052175346;
      3:  return 64'd534100635;
      4:  return 64'd268086748;
      5:  return 64'd134174063;
      6:  return 64'd67103403;
      7:  return 64'd33553749;
      8:  return 64'd16777131;
      9:  return 64'd8388597;
      10: return 64'd4194303;
      default: begin
        if (i <= 32) return longint'(64'd1 << (32 - i));
        else         return 64'd0;
      end
    endcase
  endfunction

  // table entry rescaled to a given number of fraction bits
  function automatic longint atan_scaled(input int i, input int frac);
    longint raw;
    raw = atan_q32(i);
    return (raw + (longint'(64'd1) << (31 - frac))) >>> (32 - frac);
  endfunction

endpackage

// File: rtl/cordic_angle_rom.sv
module cordic_angle_rom #(
  parameter int ITER   = 16,
  parameter int WIDTH  = 21,
  parameter int FRAC   = 18,
  localparam int IDX_W = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [WIDTH-1:0] angle
);
  logic signed [WIDTH-1:0] tbl [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_entry
    assign tbl[g] = WIDTH'(cordic_pkg::atan_scaled(g, FRAC));
  end

  assign angle = tbl[idx];
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int WIDTH  = 21,
  parameter int IDX_W  = 4
) (
  input  cordic_pkg::cordic_mode_e mode,
  input  logic [IDX_W-1:0]         shift,
  input  logic signed [WIDTH-1:0]  angle,
  input  logic signed [WIDTH-1:0]  x_cur,
  input  logic signed [WIDTH-1:0]  y_cur,
  input  logic signed [WIDTH-1:0]  z_cur,
  output logic signed [WIDTH-1:0]  x_nxt,
  output logic signed [WIDTH-1:0]  y_nxt,
  output logic signed [WIDTH-1:0]  z_nxt
);
  logic signed [WIDTH-1:0] x_sh, y_sh;
  logic                    step_neg;

  assign x_sh = x_cur >>> shift;
  assign y_sh = y_cur >>> shift;

  // step_neg selects d = -1
  always_comb begin
    if (mode == cordic_pkg::MODE_ROTATE) step_neg = z_cur[WIDTH-1];
    else                                 step_neg = ~y_cur[WIDTH-1];
  end

  always_comb begin
    if (step_neg) begin
      x_nxt = x_cur + y_sh;
      y_nxt = y_cur - x_sh;
      z_nxt = z_cur + angle;
    end else begin
      x_nxt = x_cur - y_sh;
      y_nxt = y_cur + x_sh;
      z_nxt = z_cur - angle;
    end
  end
endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITER   = 16,
  localparam int IDX_W = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load,
  output logic             busy,
  output logic             last,
  output logic [IDX_W-1:0] step,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(ITER - 1);

  assign load = start & ~busy;
  assign last = busy & (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      step <= step + IDX_W'(1);
      end
    end
  end

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_latency_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && $past(step) == LAST_STEP));

  p_busy_advance_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && step == $past(step) + IDX_W'(1)));
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
  parameter int DATA_W  = 18,
  parameter int FRAC_W  = 15,
  parameter int GUARD_W = 3,
  parameter int ITER    = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     mode,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_in,
  input  logic signed [DATA_W-1:0] z_in,
  output logic                     done,
  output logic signed [DATA_W-1:0] x_out,
  output logic signed [DATA_W-1:0] y_out,
  output logic signed [DATA_W-1:0] z_out
);
  import cordic_pkg::*;

  localparam int IW    = DATA_W + GUARD_W;
  localparam int IDX_W = (ITER > 1) ? $clog2(ITER) : 1;

  function automatic logic signed [DATA_W-1:0] narrow(input logic signed [IW-1:0] v);
    logic signed [IW:0] t;
    t = {v[IW-1], v} + (IW+1)'(1 << (GUARD_W - 1));
    return t[IW-1:GUARD_W];
  endfunction

  logic             load, busy, last;
  logic [IDX_W-1:0] step;
  cordic_mode_e     mode_r;
  logic signed [IW-1:0] x_r, y_r, z_r;
  logic signed [IW-1:0] x_n, y_n, z_n;
  logic signed [IW-1:0] angle;

  cordic_ctrl #(.ITER(ITER)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .busy(busy),
    .last(last), .step(step), .done(done)
  );

  cordic_angle_rom #(.ITER(ITER), .WIDTH(IW), .FRAC(FRAC_W + GUARD_W)) u_rom (
    .idx(step), .angle(angle)
  );

  cordic_stage #(.WIDTH(IW), .IDX_W(IDX_W)) u_stage (
    .mode(mode_r), .shift(step), .angle(angle),
    .x_cur(x_r), .y_cur(y_r), .z_cur(z_r),
    .x_nxt(x_n), .y_nxt(y_n), .z_nxt(z_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= MODE_ROTATE;
      x_r    <= '0;
      y_r    <= '0;
      z_r    <= '0;
    end else if (load) begin
      mode_r <= cordic_mode_e'(mode);
      x_r    <= {x_in, {GUARD_W{1'b0}}};
      y_r    <= {y_in, {GUARD_W{1'b0}}};
      z_r    <= {z_in, {GUARD_W{1'b0}}};
    end else if (busy) begin
      x_r <= x_n;
      y_r <= y_n;
      z_r <= z_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_out <= '0;
      y_out <= '0;
      z_out <= '0;
    end else if (last) begin
      x_out <= narrow(x_n);
      y_out <= narrow(y_n);
      z_out <= narrow(z_n);
    end
  end

  // R2: in rotation the angle moves toward zero
  p_rot_dir_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_r == MODE_ROTATE) |-> ((z_r >= 0) == (z_n <= z_r)));

  // R3: in vectoring a non-negative y adds angle
  p_vec_dir_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_r == MODE_VECTOR) |-> ((y_r >= 0) == (z_n >= z_r)));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(x_out) && $stable(y_out) && $stable(z_out)));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!done && x_out == '0 && y_out == '0 && z_out == '0));
endmodule

// File: tb/test_cordic_rotator.sv
module test_cordic_rotator;
  localparam int DATA_W = 18;
  localparam int FRAC_W = 15;
  localparam int ITER   = 16;
  localparam real GAIN  = 1.646760258;
  localparam real TOL   = 0.003;
  localparam real PI    = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic signed [DATA_W-1:0] x_in = '0, y_in = '0, z_in = '0;
  logic done;
  logic signed [DATA_W-1:0] x_out, y_out, z_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cordic_rotator #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .GUARD_W(3), .ITER(ITER)) i_cordic_rotator (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .done(done), .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  always #10 clk = ~clk;

  function automatic logic signed [DATA_W-1:0] to_fx(input real v);
    real s;
    s = v * 32768.0;
    return DATA_W'($rtoi(s >= 0.0 ? s + 0.5 : s - 0.5));
  endfunction

  function automatic real from_fx(input logic signed [DATA_W-1:0] v);
    return $itor(v) / 32768.0;
  endfunction

  task automatic check_real(input string req, input string what, input real act, input real exp);
    checks++;
    if ((act - exp > TOL) || (exp - act > TOL)) begin
      errors++;
      $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // launches one operation; returns rising edges until done (counted from accept edge)
  task automatic launch(input logic m, input real xv, input real yv, input real zv, output int lat);
    @(negedge clk);
    mode = m; x_in = to_fx(xv); y_in = to_fx(yv); z_in = to_fx(zv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < ITER + 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset_r1();
    check_int("R1", "done after reset", int'(done), 0);
    check_int("R1", "x_out after reset", int'(x_out), 0);
    check_int("R1", "y_out after reset", int'(y_out), 0);
    check_int("R1", "z_out after reset", int'(z_out), 0);
  endtask

  // R9: gain-compensated unit vector gives cos/sin
  task automatic t_cos_sin_r9(input real deg, input string req);
    int lat;
    real a;
    a = deg * PI / 180.0;
    launch(1'b0, 0.607253, 0.0, a, lat);
    check_int("R5", "rotation latency", lat, ITER);
    check_real(req, "cos", from_fx(x_out), $cos(a));
    check_real(req, "sin", from_fx(y_out), $sin(a));
    check_real("R2", "residual angle", from_fx(z_out), 0.0);
  endtask

  // R2: general vector rotation with gain
  task automatic t_rotate_r2(input real xv, input real yv, input real deg);
    int lat;
    real a;
    a = deg * PI / 180.0;
    launch(1'b0, xv, yv, a, lat);
    check_real("R2", "rotated x", from_fx(x_out), GAIN * (xv * $cos(a) - yv * $sin(a)));
    check_real("R2", "rotated y", from_fx(y_out), GAIN * (yv * $cos(a) + xv * $sin(a)));
  endtask

  task automatic t_vector_r3(input real xv, input real yv, input real zv);
    int lat;
    launch(1'b1, xv, yv, zv, lat);
    check_int("R5", "vectoring latency", lat, ITER);
    check_real("R3", "magnitude", from_fx(x_out), GAIN * $sqrt(xv * xv + yv * yv));
    check_real("R3", "y driven to zero", from_fx(y_out), 0.0);
    check_real("R3", "angle", from_fx(z_out), zv + $atan2(yv, xv));
  endtask

  task automatic t_busy_start_r7();
    int lat;
    int pulses;
    real a;
    a = 40.0 * PI / 180.0;
    @(negedge clk);
    mode = 1'b0; x_in = to_fx(0.607253); y_in = '0; z_in = to_fx(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < ITER + 20) begin
      if (lat == 5) begin
        mode = 1'b1; x_in = to_fx(0.3); y_in = to_fx(-0.9); z_in = to_fx(1.0); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check_int("R7", "latency unchanged by second start", lat, ITER);
    check_real("R7", "cos kept from first start", from_fx(x_out), $cos(a));
    check_real("R7", "sin kept from first start", from_fx(y_out), $sin(a));
    @(negedge clk);
    check_int("R6", "done drops after one cycle", int'(done), 0);
    pulses = 0;
    for (int k = 0; k < ITER + 4; k++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    check_int("R7", "no extra done from ignored start", pulses, 0);
  endtask

  task automatic t_hold_r8();
    logic signed [DATA_W-1:0] hx, hy, hz;
    hx = x_out; hy = y_out; hz = z_out;
    @(negedge clk);
    mode = 1'b1; x_in = to_fx(0.1); y_in = to_fx(0.2); z_in = to_fx(0.3);
    repeat (6) @(negedge clk);
    check_int("R8", "x_out holds", int'(x_out), int'(hx));
    check_int("R8", "y_out holds", int'(y_out), int'(hy));
    check_int("R8", "z_out holds", int'(z_out), int'(hz));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r1();
    t_cos_sin_r9(30.0, "R9");
    t_cos_sin_r9(-45.0, "R9");
    t_cos_sin_r9(0.0, "R9");
    t_cos_sin_r9(75.0, "R9");
    t_cos_sin_r9(95.0, "R4");
    t_cos_sin_r9(-99.0, "R4");
    t_rotate_r2(0.5, 0.25, 30.0);
    t_rotate_r2(-0.3, 0.4, -60.0);
    t_vector_r3(0.8, 0.6, 0.0);
    t_vector_r3(0.5, -0.7, 0.0);
    t_vector_r3(0.9, 0.2, 0.25);
    t_busy_start_r7();
    t_hold_r8();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule